// File: doc/BRIEF.md
# Configurable Serial Register Port

This block is a synchronous serial slave that gives an external controller read and write access to a small bank of configuration registers. Every transfer opens with an instruction byte. That byte carries a read/write flag and a 5-bit register address. Data bytes follow it until the fixed length of the addressed register is reached. The port then waits for the next instruction, so transfers can follow one another without any framing pin toggling.

A control register inside the bank selects three things at run time: the bit order (most-significant or least-significant bit first), the pin mode, and the address map. In 2-wire mode one bidirectional data pin carries both directions. In 3-wire mode that pin is input-only and read data leaves on a separate output. The mode bit for the address map decides whether addresses 0x07 to 0x0A reach four segment control words for memory profiles, or two sweep control words.

Chip select and a resync input both abort a partial transfer and restore framing. The serial clock and the framing pins are sampled by a faster core clock, and the serial clock edges are detected from those samples.

Top module: `sreg_port`

## Requirements
- R1: The first 8 bits of a transfer form the instruction. Bit 7 = 1 means read and 0 means write. Bits 4:0 are the register address. Bits 6:5 are ignored.
- R2: Register lengths in bytes are fixed: 0x00: 4, 0x01: 2, 0x02: 3, 0x03: 1, 0x04: 4, 0x05: 2, 0x06: 2, 0x07–0x0A: 4, and 0x0B–0x1F: 1. After the last data bit the port expects a new instruction without any framing pin toggling.
- R3: The control register lives at address 0x00. Bit 0 selects LSB-first, bit 1 selects 3-wire mode and bit 2 enables sweep mode. Its value appears on `ctrl_o` and governs transfers from the next one onward.
- R4: In MSB-first order the instruction is sent bit 7 first, and the data is sent from the register's top bit down to bit 0.
- R5: In LSB-first order the instruction is sent bit 0 first, and the data is sent from bit 0 up to the register's top bit.
- R6: Input bits are sampled on rising serial clock edges. Read bits are driven after falling edges. The first data bit follows the falling edge after the eighth instruction bit.
- R7: In 2-wire mode, `sdio_oe` is 1 only during the data phase of a read. Read data appears on `sdio_out`, and `sdo` stays 0.
- R8: In 3-wire mode, read data appears on `sdo` and `sdio_oe` stays 0.
- R9: `cs_n` = 1 or `resync` = 1 aborts the current transfer. A partly written register keeps its old value, and the next transfer starts with an instruction.
- R10: A write takes effect only when all bytes of the register have arrived. A read returns the last completed write to that register, or 0 after reset.
- R11: With sweep mode off, addresses 0x07–0x0A reach four segment words. With sweep mode on, 0x07 reaches the falling sweep word (`fall_word_o`) and 0x08 reaches the rising sweep word (`rise_word_o`). These two words are stored apart from the segment words, and the segment words keep their values.
- R12: Addresses 0x09–0x0A with sweep mode on, and addresses 0x0B–0x1F in either mode, read as 0 and ignore writes.
- R13: After reset all registers are 0, `sdio_oe` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low chip select; high aborts a transfer |
| resync | input | 1 | High aborts a transfer and restores framing |
| sdio_in | input | 1 | Serial data input (the data pin in both modes) |
| sdio_out | output | 1 | Read data toward the data pin in 2-wire mode |
| sdio_oe | output | 1 | Output enable of the data pin driver |
| sdo | output | 1 | Read data output in 3-wire mode |
| ctrl_o | output | 32 | Current control register value |
| fall_word_o | output | 32 | Falling sweep control word |
| rise_word_o | output | 32 | Rising sweep control word |

## Verification
The bench builds the port with its default of four bytes per register word. With that width, every register length from one to four bytes can be reached, and the bit index runs over the full 32-bit span in both bit orders. The bench flips the bit order, the pin mode and the sweep map through the port itself. It then checks each setting by readback, and it checks that the segment storage survives a sweep session.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W = 5;
  localparam int LEN_W  = 3;
  localparam int NSLOT  = 13;
  localparam int SLOT_W = 4;

  typedef enum logic {PH_INST, PH_DATA} phase_t;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_t;

  function automatic logic [LEN_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    logic [LEN_W-1:0] n;
    case (a)
      5'h00, 5'h04:                      n = 3'd4;
      5'h01, 5'h05, 5'h06:               n = 3'd2;
      5'h02:                             n = 3'd3;
      5'h07, 5'h08, 5'h09, 5'h0A:        n = 3'd4;
      default:                           n = 3'd1;
    endcase
    return n;
  endfunction

  function automatic slot_t slot_map(input logic [ADDR_W-1:0] a, input logic sweep);
    slot_t s;
    s.hit  = 1'b0;
    s.slot = '0;
    if (a <= 5'h06) begin
      s.hit  = 1'b1;
      s.slot = SLOT_W'(a);
    end else if (a <= 5'h0A) begin
      if (!sweep) begin
        s.hit  = 1'b1;
        s.slot = SLOT_W'(a);
      end else if (a == 5'h07) begin
        s.hit  = 1'b1;
        s.slot = 4'd11;
      end else if (a == 5'h08) begin
        s.hit  = 1'b1;
        s.slot = 4'd12;
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/sreg_frame.sv
module sreg_frame
  import sreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                resync,
  input  logic                sdi,
  input  logic                lsb_first,
  input  logic [LEN_W-1:0]    reg_len_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                inst_rd_o,
  output logic [ADDR_W-1:0]   inst_addr_o,
  output logic                data_phase_o,
  output logic                wr_en_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic                out_bit_o
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int IDX_W = $clog2(DATA_W);

  phase_t              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   sh_q, sh_d, sh_in;
  logic                rd_q, rd_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic                obit_q, obit_d;
  logic                sclk_q;

  logic                abort, rise, fall;
  logic [CNT_W-1:0]    nbits, shamt;
  logic                last_inst, last_data;
  logic [IDX_W-1:0]    idx;

  assign abort = cs_n | resync;
  assign rise  = sclk & ~sclk_q;
  assign fall  = ~sclk & sclk_q;

  assign sh_in = lsb_first ? {sdi, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], sdi};
  assign nbits = CNT_W'(reg_len_i) << 3;
  assign shamt = CNT_W'(DATA_W) - nbits;
  assign last_inst = (phase_q == PH_INST) && (cnt_q == CNT_W'(7));
  assign last_data = (phase_q == PH_DATA) && (cnt_q == nbits - CNT_W'(1));
  assign idx = lsb_first ? IDX_W'(cnt_q) : IDX_W'(nbits - CNT_W'(1) - cnt_q);

  assign wr_data_o = lsb_first ? (sh_in >> shamt) : (sh_in & ({DATA_W{1'b1}} >> shamt));
  assign wr_en_o   = !abort && rise && last_data && !rd_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    obit_d  = obit_q;
    if (abort) begin
      phase_d = PH_INST;
      cnt_d   = '0;
      obit_d  = 1'b0;
    end else if (rise) begin
      sh_d = sh_in;
      if (last_inst) begin
        phase_d = PH_DATA;
        cnt_d   = '0;
        rd_d    = lsb_first ? sh_in[DATA_W-1] : sh_in[7];
        addr_d  = lsb_first ? sh_in[DATA_W-4:DATA_W-8] : sh_in[ADDR_W-1:0];
      end else if (last_data) begin
        phase_d = PH_INST;
        cnt_d   = '0;
        obit_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (fall && phase_q == PH_DATA && rd_q) begin
      obit_d = rd_data_i[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INST;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      obit_q  <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (rise) sh_q <= sh_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      obit_q  <= obit_d;
    end
  end

  assign inst_rd_o    = rd_q;
  assign inst_addr_o  = addr_q;
  assign data_phase_o = (phase_q == PH_DATA);
  assign out_bit_o    = obit_q;

  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (phase_q == PH_INST && cnt_q == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (cnt_q < nbits));

  // R1
  inst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && rise && last_inst) |=> (phase_q == PH_DATA));

  // R6
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort && !rise && !fall) |=> $stable(obit_q));
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  fall_o,
  output logic [DATA_W-1:0]  rise_o
);
  logic [NSLOT-1:0][DATA_W-1:0] mem_q;
  logic [NSLOT-1:0]             we;
  logic                         sweep;
  slot_t                        sel;

  assign sweep = mem_q[0][2];
  assign sel   = slot_map(addr_i, sweep);

  for (genvar g = 0; g < NSLOT; g++) begin : g_we
    assign we[g] = wr_en_i && sel.hit && (sel.slot == SLOT_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (we[i]) mem_q[i] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = sel.hit ? mem_q[sel.slot] : '0;
  assign ctrl_o    = mem_q[0];
  assign fall_o    = mem_q[11];
  assign rise_o    = mem_q[12];

  // R12
  miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !sel.hit) |=> $stable(mem_q));

  // R11
  seg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sweep && addr_i == 5'h07) |=> $stable(mem_q[7]));
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_pkg::*;
#(
  parameter int MAX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   cs_n,
  input  logic                   resync,
  input  logic                   sdio_in,
  output logic                   sdio_out,
  output logic                   sdio_oe,
  output logic                   sdo,
  output logic [8*MAX_BYTES-1:0] ctrl_o,
  output logic [8*MAX_BYTES-1:0] fall_word_o,
  output logic [8*MAX_BYTES-1:0] rise_word_o
);
  localparam int DATA_W = 8 * MAX_BYTES;

  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic               inst_rd, data_phase, wr_en, out_bit;
  logic [ADDR_W-1:0]  inst_addr;
  logic [DATA_W-1:0]  wr_data, rd_data, ctrl;
  logic [LEN_W-1:0]   reg_len;
  logic               three_wire;

  assign reg_len    = reg_bytes(inst_addr);
  assign three_wire = ctrl[1];

  sreg_frame #(.DATA_W(DATA_W)) u_frame (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .resync       (resync),
    .sdi          (sdio_in),
    .lsb_first    (ctrl[0]),
    .reg_len_i    (reg_len),
    .rd_data_i    (rd_data),
    .inst_rd_o    (inst_rd),
    .inst_addr_o  (inst_addr),
    .data_phase_o (data_phase),
    .wr_en_o      (wr_en),
    .wr_data_o    (wr_data),
    .out_bit_o    (out_bit)
  );

  sreg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_i    (inst_addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .ctrl_o    (ctrl),
    .fall_o    (fall_word_o),
    .rise_o    (rise_word_o)
  );

  assign sdio_out = out_bit;
  assign sdio_oe  = data_phase & inst_rd & ~three_wire & ~cs_n & ~resync;
  assign sdo      = data_phase & inst_rd & three_wire & out_bit;
  assign ctrl_o   = ctrl;

  // R7
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sdio_oe |-> (!ctrl_o[1] && !cs_n));

  // R8
  sdo_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ctrl_o[1] |-> !sdo);
endmodule

// File: tb/sreg_port_bench.sv
module sreg_port_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, sclk, cs_n, resync, sdio_in;
  logic        sdio_out, sdio_oe, sdo;
  logic [31:0] ctrl_o, fall_word_o, rise_word_o;

  sreg_port u_sreg_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .resync(resync),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo),
    .ctrl_o(ctrl_o), .fall_word_o(fall_word_o), .rise_word_o(rise_word_o)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  bit bench_lsb = 0, bench_3w = 0;
  bit oe_data_all, oe_data_any, oe_inst_any, sdo_any;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] cap_word;
  int          rd_seq = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic b, output logic r, output logic oe, output logic so);
    @(negedge clk);
    sclk = 1'b0;
    sdio_in = b;
    repeat (2) @(negedge clk);
    r  = bench_3w ? sdo : sdio_out;
    oe = sdio_oe;
    so = sdo;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [1:0] junk, input logic [4:0] a, input int nb,
                      input logic [31:0] wd, input int stop_at, output logic [31:0] rv);
    logic [7:0] ins;
    logic b, r, oe, so;
    ins = {rd, junk, a};
    rv = '0;
    oe_data_all = 1; oe_data_any = 0; oe_inst_any = 0; sdo_any = 0;
    for (int k = 0; k < 8 + 8 * nb; k++) begin
      if (stop_at >= 0 && k == stop_at) break;
      if (bench_lsb) b = (k < 8) ? ins[k] : wd[k-8];
      else           b = (k < 8) ? ins[7-k] : wd[8*nb-1-(k-8)];
      bit_cycle(b, r, oe, so);
      if (k < 8) oe_inst_any |= oe;
      else begin
        oe_data_all &= oe;
        oe_data_any |= oe;
        sdo_any |= so;
        if (bench_lsb) rv[k-8] = r;
        else           rv[8*nb-1-(k-8)] = r;
      end
    end
  endtask

  task automatic wr(input logic [4:0] a, input int nb, input logic [31:0] v);
    logic [31:0] dummy;
    xfer(1'b0, 2'b00, a, nb, v, -1, dummy);
  endtask

  task automatic rd_chk(input logic [4:0] a, input int nb, input logic [31:0] exp,
                        input string tag, input logic [1:0] junk = 2'b00);
    logic [31:0] rv;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(1'b1, junk, a, nb, 32'h0, -1, rv);
    cap_word = rv;
    rd_seq++;
  endtask

  initial begin : monitor
    logic [31:0] e;
    string t;
    forever begin
      @(rd_seq);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(cap_word === e, t, cap_word, e);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin : main
    logic [31:0] dummy;
    rst_n = 0; sclk = 0; cs_n = 1; resync = 0; sdio_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(sdio_oe === 1'b0, "R13 oe after reset", {31'h0, sdio_oe}, 32'h0);
    chk(sdo === 1'b0, "R13 sdo after reset", {31'h0, sdo}, 32'h0);
    chk(ctrl_o === 32'h0, "R13 ctrl after reset", ctrl_o, 32'h0);
    chk(fall_word_o === 32'h0, "R13 fall word after reset", fall_word_o, 32'h0);
    cs_n = 0;
    repeat (2) @(negedge clk);
    rd_chk(5'h04, 4, 32'h0, "R13 reg 0x04 reads zero after reset");

    // R4 MSB-first writes and reads of every length (R2, R10)
    wr(5'h04, 4, 32'h12345678);
    rd_chk(5'h04, 4, 32'h12345678, "R4 msb 4-byte readback");
    chk(oe_data_all == 1, "R7 oe high across read data", {31'h0, oe_data_all}, 32'h1);
    chk(oe_inst_any == 0, "R7 oe low during instruction", {31'h0, oe_inst_any}, 32'h0);
    chk(sdo_any == 0, "R7 sdo low in 2-wire read", {31'h0, sdo_any}, 32'h0);
    wr(5'h01, 2, 32'h0000BEEF);
    wr(5'h02, 3, 32'h00A5C3F0);
    wr(5'h03, 1, 32'h0000005A);
    rd_chk(5'h01, 2, 32'h0000BEEF, "R2 2-byte register");
    rd_chk(5'h02, 3, 32'h00A5C3F0, "R2 3-byte register");
    rd_chk(5'h03, 1, 32'h0000005A, "R2 1-byte register");
    @(negedge clk);
    chk(sdio_oe === 1'b0, "R7 oe low after read ends", {31'h0, sdio_oe}, 32'h0);
    // R1 bits 6:5 ignored
    rd_chk(5'h04, 4, 32'h12345678, "R1 instruction bits 6:5 ignored", 2'b11);

    // R9 abort by chip select and by resync
    wr(5'h05, 2, 32'h00001357);
    xfer(1'b0, 2'b00, 5'h05, 2, 32'h0000FFFF, 13, dummy);
    @(negedge clk); cs_n = 1; repeat (3) @(negedge clk); cs_n = 0;
    rd_chk(5'h05, 2, 32'h00001357, "R9 chip-select abort keeps value");
    xfer(1'b0, 2'b00, 5'h05, 2, 32'h0000AAAA, 3, dummy);
    @(negedge clk); resync = 1; repeat (2) @(negedge clk); resync = 0;
    rd_chk(5'h05, 2, 32'h00001357, "R9 resync realigns framing");

    // R11 segment words with sweep off
    wr(5'h07, 4, 32'hA0A0A0A0);
    wr(5'h09, 4, 32'h09090909);

    // R3 switch to LSB-first
    wr(5'h00, 4, 32'h00000001);
    chk(ctrl_o === 32'h1, "R3 ctrl after write", ctrl_o, 32'h1);
    bench_lsb = 1;
    // R5 LSB-first order
    rd_chk(5'h04, 4, 32'h12345678, "R5 lsb read of 0x04");
    wr(5'h06, 2, 32'h000000C3);
    rd_chk(5'h06, 2, 32'h000000C3, "R5 lsb write then read 0x06");

    // R11 sweep map
    wr(5'h00, 4, 32'h00000005);
    chk(ctrl_o === 32'h5, "R3 sweep bit set", ctrl_o, 32'h5);
    wr(5'h07, 4, 32'h11112222);
    wr(5'h08, 4, 32'h33334444);
    chk(fall_word_o === 32'h11112222, "R11 falling word output", fall_word_o, 32'h11112222);
    chk(rise_word_o === 32'h33334444, "R11 rising word output", rise_word_o, 32'h33334444);
    rd_chk(5'h07, 4, 32'h11112222, "R11 0x07 reaches falling word");
    wr(5'h09, 4, 32'hDEADBEEF);
    rd_chk(5'h09, 4, 32'h0, "R12 0x09 unused in sweep mode");
    wr(5'h00, 4, 32'h00000001);
    rd_chk(5'h07, 4, 32'hA0A0A0A0, "R11 segment word kept");
    rd_chk(5'h09, 4, 32'h09090909, "R12 ignored write left segment 0x09");
    chk(fall_word_o === 32'h11112222, "R11 falling word kept", fall_word_o, 32'h11112222);

    // R8 3-wire mode with MSB-first
    wr(5'h00, 4, 32'h00000002);
    bench_lsb = 0; bench_3w = 1;
    rd_chk(5'h04, 4, 32'h12345678, "R8 3-wire read on sdo");
    chk(oe_data_any == 0, "R8 oe stays low in 3-wire", {31'h0, oe_data_any}, 32'h0);
    wr(5'h15, 1, 32'h000000FF);
    rd_chk(5'h15, 1, 32'h0, "R12 unused address reads zero");
    rd_chk(5'h03, 1, 32'h0000005A, "R6 back-to-back 1-byte read");

    repeat (4) @(negedge clk);
    wait (exp_q.size() == 0);
    summary();
  end
endmodule